// File: doc/BRIEF.md
# Transmit Ring Write Port with Bus Timeout

This block takes single-word host writes aimed at a paged transmit ring in packet memory. An accepted word is held in one holding register and offered to packet memory as a request. The arbiter treats that request as top priority. When the grant arrives, the word is written at the current ring position and the position moves on by one word. A host can learn that its cycle finished in either of two ways. It can wait for the one-cycle ready strobe, or it can poll the busy flag until it reads low.

The ring position is a page number joined with a byte offset inside the page. The offset wraps at the end of the page and the page number then steps up. Software may load a new page number at any time, and doing so clears the offset.

A programmable bus-integrity timer watches every write that is waiting for a grant. If the wait lasts too long, the write is dropped and an interrupt flag latches. While that flag is set, both LED outputs blink together at a slow rate taken from a prescaler. Clearing the flag stops the blinking.

Top module: `tx_write_port`

## Requirements
- R1: After reset, busy, ready, interrupt and both LEDs are low, and the write address is zero.
- R2: The write address output is the 12-bit page number in bits [19:8] joined with the 8-bit byte offset in bits [7:0]. Each completed write adds 4 to the offset.
- R3: A write completed at offset 252 sets the offset to 0 and adds one to the page number. Page 4095 wraps to page 0.
- R4: A page load sets the page number and clears the offset on the next edge. A load takes precedence over an advance in the same cycle.
- R5: A write request while not busy is accepted. From the next cycle, busy and the memory request are high, and the held data equals the written word.
- R6: A write request while busy is ignored. The held data and the address do not change.
- R7: A grant while busy completes the write. In the next cycle ready is high for exactly one cycle and busy is low.
- R8: With a nonzero period P, a write still without a grant at the P-th edge after acceptance is dropped. Busy falls, the interrupt rises, ready stays low and the address does not advance.
- R9: A grant at the same edge at which the timer would expire completes the write normally and raises no interrupt.
- R10: A period of zero disables the timer, so a write may wait for any length of time.
- R11: The interrupt stays high until a clear request. When a new timeout and a clear fall in the same cycle, the timeout wins.
- R12: The two LEDs are always equal and are low while the interrupt is low. While the interrupt is high, they toggle every BLINK_DIV cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_wr_en | input | 1 | Host write request for one word |
| host_wr_data | input | 32 | Host write word |
| page_load | input | 1 | Load a new page number |
| page_load_val | input | 12 | Page number to load |
| tmo_period | input | 16 | Timeout period in cycles, 0 disables |
| irq_clear | input | 1 | Clear the timeout interrupt |
| mem_gnt | input | 1 | Packet memory grant for the held write |
| mem_req | output | 1 | Packet memory request, top priority |
| mem_addr | output | 20 | Current write address {page, offset} |
| mem_wdata | output | 32 | Held write word |
| wr_ready | output | 1 | One-cycle completion strobe |
| wr_busy | output | 1 | A write is still pending |
| tmo_irq | output | 1 | Timeout interrupt flag |
| led0 | output | 1 | Timeout indicator LED, blinks with led1 |
| led1 | output | 1 | Timeout indicator LED, blinks with led0 |

## Verification
Two kinds of event can land on one edge: a grant can arrive at the very edge where the timer expires, and a page load can coincide with the address advance of a completing write. The bench sets up each collision with directed stimulus. It holds the grant off for exactly P-1 edges and then raises it on the P-th, and it asserts the page load in the same cycle as the grant. For the first collision the outcome must be a normal completion with the address advanced and no interrupt. For the second, the address must show the loaded page at offset zero. A further collision is a timeout that coincides with an interrupt clear; here the interrupt must stay set.

// File: rtl/txw_pkg.sv
package txw_pkg;
    localparam int PAGE_W     = 12;
    localparam int OFS_W      = 8;
    localparam int ADDR_W     = PAGE_W + OFS_W;
    localparam int DATA_W     = 32;
    localparam int TMR_W      = 16;
    localparam int WORD_BYTES = 4;
    localparam logic [OFS_W-1:0] OFS_LAST = OFS_W'((1 << OFS_W) - WORD_BYTES);

    typedef struct packed {
        logic [PAGE_W-1:0] page;
        logic [OFS_W-1:0]  ofs;
    } ring_pos_t;

    typedef struct packed {
        logic              valid;
        logic [DATA_W-1:0] data;
    } hold_t;

    function automatic ring_pos_t pos_step(input ring_pos_t p);
        ring_pos_t n;
        if (p.ofs == OFS_LAST) begin
            n.page = p.page + PAGE_W'(1);
            n.ofs  = '0;
        end else begin
            n.page = p.page;
            n.ofs  = p.ofs + OFS_W'(WORD_BYTES);
        end
        return n;
    endfunction
endpackage

// File: rtl/txw_pos_ctr.sv
module txw_pos_ctr
    import txw_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [PAGE_W-1:0] load_page,
    input  logic              adv,
    output ring_pos_t         pos
);
    ring_pos_t pos_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pos_q <= '0;
        end else if (load) begin
            pos_q.page <= load_page;
            pos_q.ofs  <= '0;
        end else if (adv) begin
            pos_q <= pos_step(pos_q);
        end
    end

    assign pos = pos_q;
endmodule

// File: rtl/txw_bus_timer.sv
module txw_bus_timer
    import txw_pkg::*;
#(
    parameter int BLINK_DIV = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             pending,
    input  logic             gnt,
    input  logic [TMR_W-1:0] period,
    input  logic             clr,
    output logic             abort,
    output logic             irq,
    output logic             blink
);
    localparam int BLK_W = (BLINK_DIV > 2) ? $clog2(BLINK_DIV) : 1;
    localparam logic [BLK_W-1:0] BLK_LAST = BLK_W'(BLINK_DIV - 1);

    logic [TMR_W-1:0] wait_q;
    logic [BLK_W-1:0] presc_q;
    logic             irq_q;
    logic             blink_q;

    assign abort = pending && !gnt && (period != '0) &&
                   (wait_q == period - TMR_W'(1));

    always_ff @(posedge clk) begin
        if (rst || !pending || gnt) begin
            wait_q <= '0;
        end else begin
            wait_q <= wait_q + TMR_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            irq_q <= 1'b0;
        end else if (abort) begin
            irq_q <= 1'b1;
        end else if (clr) begin
            irq_q <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || !irq_q) begin
            presc_q <= '0;
            blink_q <= 1'b0;
        end else if (presc_q == BLK_LAST) begin
            presc_q <= '0;
            blink_q <= !blink_q;
        end else begin
            presc_q <= presc_q + BLK_W'(1);
        end
    end

    assign irq   = irq_q;
    assign blink = blink_q && irq_q;
endmodule

// File: rtl/tx_write_port.sv
module tx_write_port
    import txw_pkg::*;
#(
    parameter int BLINK_DIV = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              host_wr_en,
    input  logic [DATA_W-1:0] host_wr_data,
    input  logic              page_load,
    input  logic [PAGE_W-1:0] page_load_val,
    input  logic [TMR_W-1:0]  tmo_period,
    input  logic              irq_clear,
    input  logic              mem_gnt,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    output logic              wr_ready,
    output logic              wr_busy,
    output logic              tmo_irq,
    output logic              led0,
    output logic              led1
);
    hold_t     hold_q;
    logic      ready_q;
    logic      accept;
    logic      done;
    logic      abort;
    logic      blink;
    ring_pos_t pos;

    assign accept = host_wr_en && !hold_q.valid;
    assign done   = hold_q.valid && mem_gnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            hold_q  <= '0;
            ready_q <= 1'b0;
        end else begin
            ready_q <= done;
            if (accept) begin
                hold_q.valid <= 1'b1;
                hold_q.data  <= host_wr_data;
            end else if (done || abort) begin
                hold_q.valid <= 1'b0;
            end
        end
    end

    txw_pos_ctr u_pos (
        .clk       (clk),
        .rst       (rst),
        .load      (page_load),
        .load_page (page_load_val),
        .adv       (done),
        .pos       (pos)
    );

    txw_bus_timer #(.BLINK_DIV(BLINK_DIV)) u_tmr (
        .clk     (clk),
        .rst     (rst),
        .pending (hold_q.valid),
        .gnt     (mem_gnt),
        .period  (tmo_period),
        .clr     (irq_clear),
        .abort   (abort),
        .irq     (tmo_irq),
        .blink   (blink)
    );

    assign mem_req   = hold_q.valid;
    assign mem_addr  = pos;
    assign mem_wdata = hold_q.data;
    assign wr_ready  = ready_q;
    assign wr_busy   = hold_q.valid;
    assign led0      = blink;
    assign led1      = blink;
endmodule

// File: rtl/tx_write_port_chk.sv
module tx_write_port_chk
    import txw_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              host_wr_en,
    input logic              page_load,
    input logic              irq_clear,
    input logic              mem_gnt,
    input logic              mem_req,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [DATA_W-1:0] mem_wdata,
    input logic              wr_ready,
    input logic              wr_busy,
    input logic              tmo_irq,
    input logic              led0,
    input logic              led1
);
    a_r5_accept: assert property (@(posedge clk) disable iff (rst)
        (host_wr_en && !wr_busy) |=> (wr_busy && mem_req));

    a_r6_hold_stable: assert property (@(posedge clk) disable iff (rst)
        (wr_busy && !mem_gnt) |=> (!wr_busy || $stable(mem_wdata)));

    a_r7_complete: assert property (@(posedge clk) disable iff (rst)
        (wr_busy && mem_gnt) |=> (wr_ready && !wr_busy));

    a_r7_one_cycle: assert property (@(posedge clk) disable iff (rst)
        wr_ready |=> !wr_ready);

    a_r4_load_clears: assert property (@(posedge clk) disable iff (rst)
        page_load |=> (mem_addr[OFS_W-1:0] == '0));

    a_r8_no_ready_on_abort: assert property (@(posedge clk) disable iff (rst)
        $rose(tmo_irq) |-> (!wr_ready && !wr_busy));

    a_r11_irq_hold: assert property (@(posedge clk) disable iff (rst)
        (tmo_irq && !irq_clear) |=> tmo_irq);

    a_r12_leds_match: assert property (@(posedge clk) disable iff (rst)
        led0 == led1);

    a_r12_dark_when_idle: assert property (@(posedge clk) disable iff (rst)
        !tmo_irq |-> (!led0 && !led1));
endmodule

bind tx_write_port tx_write_port_chk i_chk (
    .clk        (clk),
    .rst        (rst),
    .host_wr_en (host_wr_en),
    .page_load  (page_load),
    .irq_clear  (irq_clear),
    .mem_gnt    (mem_gnt),
    .mem_req    (mem_req),
    .mem_addr   (mem_addr),
    .mem_wdata  (mem_wdata),
    .wr_ready   (wr_ready),
    .wr_busy    (wr_busy),
    .tmo_irq    (tmo_irq),
    .led0       (led0),
    .led1       (led1)
);

// File: tb/test_tx_write_port.sv
module test_tx_write_port;
    import txw_pkg::*;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              host_wr_en = 1'b0;
    logic [DATA_W-1:0] host_wr_data = '0;
    logic              page_load = 1'b0;
    logic [PAGE_W-1:0] page_load_val = '0;
    logic [TMR_W-1:0]  tmo_period = '0;
    logic              irq_clear = 1'b0;
    logic              mem_gnt = 1'b0;
    logic              mem_req;
    logic [ADDR_W-1:0] mem_addr;
    logic [DATA_W-1:0] mem_wdata;
    logic              wr_ready;
    logic              wr_busy;
    logic              tmo_irq;
    logic              led0;
    logic              led1;

    int checks = 0;
    int errors = 0;
    bit finished = 0;
    logic [ADDR_W-1:0] exp_addr = '0;

    always #2 clk = !clk;

    tx_write_port #(.BLINK_DIV(4)) i_tx_write_port (
        .clk(clk), .rst(rst), .host_wr_en(host_wr_en), .host_wr_data(host_wr_data),
        .page_load(page_load), .page_load_val(page_load_val), .tmo_period(tmo_period),
        .irq_clear(irq_clear), .mem_gnt(mem_gnt), .mem_req(mem_req), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .wr_ready(wr_ready), .wr_busy(wr_busy), .tmo_irq(tmo_irq),
        .led0(led0), .led1(led1)
    );

    function automatic logic [ADDR_W-1:0] f_next(input logic [ADDR_W-1:0] a);
        if (a[OFS_W-1:0] == 8'd252) return {a[ADDR_W-1:OFS_W] + 12'd1, 8'd0};
        return {a[ADDR_W-1:OFS_W], a[OFS_W-1:0] + 8'd4};
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    task automatic load_page(input logic [PAGE_W-1:0] p);
        page_load = 1'b1; page_load_val = p;
        tick();
        page_load = 1'b0;
        exp_addr = {p, 8'd0};
        check("R4 load", 32'(mem_addr), 32'(exp_addr));
    endtask

    task automatic do_write(input logic [31:0] d, input int dly, input bit second);
        host_wr_en = 1'b1; host_wr_data = d;
        tick();
        host_wr_en = 1'b0;
        check("R5 busy", 32'(wr_busy), 1);
        check("R5 data", mem_wdata, d);
        check("R2 addr", 32'(mem_addr), 32'(exp_addr));
        for (int i = 0; i < dly; i++) begin
            if (second && i == 0) begin host_wr_en = 1'b1; host_wr_data = ~d; end
            tick();
            host_wr_en = 1'b0;
            if (second && i == 0) begin
                check("R6 data kept", mem_wdata, d);
                check("R6 addr kept", 32'(mem_addr), 32'(exp_addr));
            end
        end
        mem_gnt = 1'b1;
        tick();
        mem_gnt = 1'b0;
        exp_addr = f_next(exp_addr);
        check("R7 ready", 32'(wr_ready), 1);
        check("R7 busy low", 32'(wr_busy), 0);
        check("R3 addr advance", 32'(mem_addr), 32'(exp_addr));
        tick();
        check("R7 ready one cycle", 32'(wr_ready), 0);
    endtask

    initial begin
        #(4 * 200000);
        checks++; errors++;
        $display("FAIL watchdog actual=hung expected=done");
        finish_run();
    end

    initial begin
        int toggles;
        logic prev;
        void'($urandom(32'h5eed_1234));
        tmo_period = 16'd200;
        repeat (3) tick();
        rst = 1'b0;
        check("R1 busy", 32'(wr_busy), 0);
        check("R1 ready", 32'(wr_ready), 0);
        check("R1 irq", 32'(tmo_irq), 0);
        check("R1 leds", 32'({led0, led1}), 0);
        check("R1 addr", 32'(mem_addr), 0);

        load_page(12'h005);
        do_write(32'hdead_beef, 2, 1);
        do_write(32'h1234_5678, 0, 0);

        // R3: page crossing and page number wrap
        load_page(12'h007);
        for (int i = 0; i < 64; i++) do_write($urandom, 0, 0);
        check("R3 next page", 32'(mem_addr), 32'({12'h008, 8'd0}));
        load_page(12'hfff);
        for (int i = 0; i < 64; i++) do_write($urandom, 0, 0);
        check("R3 page wrap", 32'(mem_addr), 0);

        // R4: load in the same cycle as the advance
        host_wr_en = 1'b1; host_wr_data = 32'h0a0a_0a0a;
        tick();
        host_wr_en = 1'b0;
        mem_gnt = 1'b1; page_load = 1'b1; page_load_val = 12'h009;
        tick();
        mem_gnt = 1'b0; page_load = 1'b0;
        exp_addr = {12'h009, 8'd0};
        check("R4 load beats advance", 32'(mem_addr), 32'(exp_addr));
        check("R7 ready with load", 32'(wr_ready), 1);
        tick();

        // random mix
        for (int n = 0; n < 150; n++) begin
            if ($urandom_range(0, 9) == 0) load_page(12'($urandom));
            do_write($urandom, int'($urandom_range(0, 4)), bit'($urandom_range(0, 1)));
        end

        // R8: timeout at the 6th edge
        tmo_period = 16'd6;
        host_wr_en = 1'b1; host_wr_data = 32'h5555_aaaa;
        tick();
        host_wr_en = 1'b0;
        repeat (5) tick();
        check("R8 still busy", 32'(wr_busy), 1);
        check("R8 no irq yet", 32'(tmo_irq), 0);
        tick();
        check("R8 busy dropped", 32'(wr_busy), 0);
        check("R8 irq set", 32'(tmo_irq), 1);
        check("R8 no ready", 32'(wr_ready), 0);
        check("R8 addr kept", 32'(mem_addr), 32'(exp_addr));

        // R12: blink every 4 cycles, LEDs together
        toggles = 0; prev = led0;
        for (int i = 0; i < 40; i++) begin
            tick();
            if (led0 !== led1) check("R12 leds equal", 32'(led1), 32'(led0));
            if (led0 !== prev) toggles++;
            prev = led0;
        end
        check("R12 toggle count", 32'(toggles), 10);
        check("R11 irq held", 32'(tmo_irq), 1);

        // R11: timeout and clear in the same cycle
        tmo_period = 16'd3;
        host_wr_en = 1'b1;
        tick();
        host_wr_en = 1'b0;
        tick(); tick();
        irq_clear = 1'b1;
        tick();
        irq_clear = 1'b0;
        check("R11 set wins", 32'(tmo_irq), 1);
        irq_clear = 1'b1;
        tick();
        irq_clear = 1'b0;
        check("R11 cleared", 32'(tmo_irq), 0);
        tick();
        check("R12 dark", 32'({led0, led1}), 0);

        // R9: grant at the expiry edge
        tmo_period = 16'd4;
        host_wr_en = 1'b1; host_wr_data = 32'hcafe_f00d;
        tick();
        host_wr_en = 1'b0;
        repeat (3) tick();
        mem_gnt = 1'b1;
        tick();
        mem_gnt = 1'b0;
        exp_addr = f_next(exp_addr);
        check("R9 ready", 32'(wr_ready), 1);
        check("R9 no irq", 32'(tmo_irq), 0);
        check("R9 addr", 32'(mem_addr), 32'(exp_addr));
        tick();

        // R10: period zero
        tmo_period = 16'd0;
        host_wr_en = 1'b1;
        tick();
        host_wr_en = 1'b0;
        repeat (80) tick();
        check("R10 still busy", 32'(wr_busy), 1);
        check("R10 no irq", 32'(tmo_irq), 0);
        mem_gnt = 1'b1;
        tick();
        mem_gnt = 1'b0;
        check("R10 completes", 32'(wr_ready), 1);
        tick();

        finish_run();
    end
endmodule